// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tags

This block sits between a serial receive deserializer and a processor register port. Each completed character arrives on a strobe together with its parity and framing verdicts, and is stored with them in a first-in first-out queue. A break strobe stores a single break marker. The processor takes characters out with a data read strobe. The block produces the receive half of a line status word. Its data-ready, overrun, parity, framing and break bits describe the oldest stored character. A summary error bit stays high while any stored character carries a flag.

A mode input chooses between the full queue and a single holding register, which is the same storage limited to one entry. A small gate state machine guards break handling. In state `GATE_OPEN`, a break strobe with no character strobe stores a break entry and takes the transition *break-taken* to `GATE_SHUT`. In `GATE_SHUT`, break strobes are ignored. A character strobe takes the transition *rearm* back to `GATE_OPEN`, and that character is stored. Every other input combination leaves the state unchanged.

Top module: `rx_fifo_status`

## Requirements
- R1: `st_dr` is 1 exactly when at least one entry is stored.
- R2: A store attempt (character, or break taken by the gate) while the queue is full sets `st_ovr`, is discarded, and leaves the stored entries and their order intact. The queue counts as full even when a data read happens in the same cycle.
- R3: `st_par`, `st_frm` and `st_brk` equal the flags of the oldest stored entry, and are all 0 when nothing is stored.
- R4: In `GATE_OPEN`, a `brk_stb` without `chr_vld` stores one entry with data 0x00 and only the break flag set.
- R5: In `GATE_SHUT`, `brk_stb` stores nothing. The next `chr_vld` returns the gate to `GATE_OPEN`. When `chr_vld` and `brk_stb` arrive together, only the character is stored.
- R6: `st_err` is 1 while any stored entry has a parity, framing or break flag. It falls when the last flagged entry is read out, and it stays correct when a store and a read happen in the same cycle.
- R7: `st_rd` clears `st_ovr`. A status read in the same cycle as a new overrun leaves `st_ovr` set.
- R8: `rd_stb` with data present puts the oldest entry's data on `rd_data` in the next cycle and removes that entry. `rd_stb` on an empty queue leaves `rd_data` and all status bits unchanged.
- R9: With `fifo_en` = 0, the capacity is one entry. A second character before a read is an overrun.
- R10: Reset clears all status outputs and `rd_data` to 0 and opens the gate.
- R11: With `fifo_en` = 1, `DEPTH` entries are held and read back in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding register |
| chr_vld | input | 1 | Character completed strobe |
| chr_data | input | 8 | Received character |
| chr_par | input | 1 | Parity error for this character |
| chr_frm | input | 1 | Framing error for this character |
| brk_stb | input | 1 | Break detected strobe |
| rd_stb | input | 1 | Processor data read |
| st_rd | input | 1 | Processor status read |
| rd_data | output | 8 | Last character read |
| st_dr | output | 1 | Data ready |
| st_ovr | output | 1 | Overrun |
| st_par | output | 1 | Parity error of oldest entry |
| st_frm | output | 1 | Framing error of oldest entry |
| st_brk | output | 1 | Break marker at oldest entry |
| st_err | output | 1 | Some stored entry is flagged |

## Verification
The checker watches these rules on every cycle:
- a stored character raises data ready;
- a store attempt into a full queue raises overrun and leaves the occupancy unchanged;
- a head flag or the summary bit is never high without data;
- a status read with no competing event clears overrun;
- a shut gate ignores break strobes.

Other properties need the bench's scenarios, because they depend on sequences of values:
- arrival order across a full queue;
- which character's flags appear at the head;
- the value held on `rd_data` after an empty read;
- single-entry behaviour in holding-register mode;
- the summary bit through simultaneous store and read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int unsigned DATA_W = 8;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxq_flags_t;

    typedef struct packed {
        rxq_flags_t        flg;
        logic [DATA_W-1:0] dat;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       single,
    input  logic                       push,
    input  logic                       pop,
    input  rxq_entry_t                 wdata,
    output rxq_entry_t                 head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = single ? (cnt != '0) : (cnt == CW'(DEPTH));
    assign occ   = cnt;
endmodule

// File: rtl/rxq_brk_gate.sv
module rxq_brk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic chr_vld,
    input  logic brk_stb,
    output logic take_brk,
    output logic shut
);
    typedef enum logic {GATE_OPEN, GATE_SHUT} gate_t;
    gate_t st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= GATE_OPEN;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt   = st;
        take_brk = 1'b0;
        unique case (st)
            GATE_OPEN: if (!chr_vld && brk_stb) begin
                take_brk = 1'b1;
                st_nxt   = GATE_SHUT;
            end
            GATE_SHUT: if (chr_vld) st_nxt = GATE_OPEN;
        endcase
    end

    assign shut = (st == GATE_SHUT);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovr_evt,
    input  logic              st_rd,
    input  logic              push_bad,
    input  logic              pop,
    input  logic              pop_bad,
    input  logic [DATA_W-1:0] pop_data,
    output logic              ovr,
    output logic              err,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned CW = $clog2(DEPTH+1);
    logic [CW-1:0] bad_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr     <= 1'b0;
            bad_cnt <= '0;
            rd_data <= '0;
        end else begin
            ovr     <= (ovr & ~st_rd) | ovr_evt;
            bad_cnt <= bad_cnt + CW'(push_bad) - CW'(pop_bad);
            if (pop) rd_data <= pop_data;
        end
    end

    assign err = (bad_cnt != '0);
endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       chr_vld,
    input  logic [7:0] chr_data,
    input  logic       chr_par,
    input  logic       chr_frm,
    input  logic       brk_stb,
    input  logic       rd_stb,
    input  logic       st_rd,
    output logic [7:0] rd_data,
    output logic       st_dr,
    output logic       st_ovr,
    output logic       st_par,
    output logic       st_frm,
    output logic       st_brk,
    output logic       st_err
);
    localparam int unsigned CW = $clog2(DEPTH+1);

    rxq_entry_t    wentry, head;
    logic          empty, full, take_brk, shut;
    logic          push_try, push_ok, pop;
    logic [CW-1:0] occ;

    always_comb begin
        if (chr_vld) begin
            wentry.dat     = chr_data;
            wentry.flg.brk = 1'b0;
            wentry.flg.frm = chr_frm;
            wentry.flg.par = chr_par;
        end else begin
            wentry.dat     = '0;
            wentry.flg.brk = 1'b1;
            wentry.flg.frm = 1'b0;
            wentry.flg.par = 1'b0;
        end
    end

    assign push_try = chr_vld | take_brk;
    assign push_ok  = push_try & ~full;
    assign pop      = rd_stb & ~empty;

    rxq_brk_gate u_gate (
        .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .brk_stb(brk_stb),
        .take_brk(take_brk), .shut(shut)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .single(~fifo_en), .push(push_ok), .pop(pop),
        .wdata(wentry), .head(head), .empty(empty), .full(full), .occ(occ)
    );

    rxq_status #(.DEPTH(DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n), .ovr_evt(push_try & full), .st_rd(st_rd),
        .push_bad(push_ok & (|wentry.flg)), .pop(pop), .pop_bad(pop & (|head.flg)),
        .pop_data(head.dat), .ovr(st_ovr), .err(st_err), .rd_data(rd_data)
    );

    assign st_dr  = ~empty;
    assign st_par = ~empty & head.flg.par;
    assign st_frm = ~empty & head.flg.frm;
    assign st_brk = ~empty & head.flg.brk;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int unsigned DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       chr_vld,
    input logic                       brk_stb,
    input logic                       rd_stb,
    input logic                       st_rd,
    input logic                       full,
    input logic                       shut,
    input logic [$clog2(DEPTH+1)-1:0] occ,
    input logic                       st_dr,
    input logic                       st_ovr,
    input logic                       st_par,
    input logic                       st_frm,
    input logic                       st_brk,
    input logic                       st_err
);
    p_dr_after_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld && !rd_stb |=> st_dr);

    p_ovr_on_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld && full |=> st_ovr);

    p_full_keeps_occ_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld && full && !rd_stb |=> $stable(occ));

    p_head_flag_needs_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_par || st_frm || st_brk) |-> st_err);

    p_shut_ignores_brk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shut && brk_stb && !chr_vld && !rd_stb |=> $stable(occ));

    p_err_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> st_dr);

    p_status_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd && !chr_vld && !brk_stb |=> !st_ovr);
endmodule

bind rx_fifo_status rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .brk_stb(brk_stb),
    .rd_stb(rd_stb), .st_rd(st_rd), .full(full), .shut(shut), .occ(occ),
    .st_dr(st_dr), .st_ovr(st_ovr), .st_par(st_par), .st_frm(st_frm),
    .st_brk(st_brk), .st_err(st_err)
);

// File: tb/test_rx_fifo_status.sv
`timescale 1ns/1ps
module test_rx_fifo_status;
    localparam int DEPTH = 16;
    localparam int NROW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b1;
    logic chr_vld = 1'b0, chr_par = 1'b0, chr_frm = 1'b0;
    logic brk_stb = 1'b0, rd_stb = 1'b0, st_rd = 1'b0;
    logic [7:0] chr_data = 8'h00;
    logic [7:0] rd_data;
    logic st_dr, st_ovr, st_par, st_frm, st_brk, st_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_fifo_status #(.DEPTH(DEPTH)) i_rx_fifo_status (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .chr_vld(chr_vld),
        .chr_data(chr_data), .chr_par(chr_par), .chr_frm(chr_frm),
        .brk_stb(brk_stb), .rd_stb(rd_stb), .st_rd(st_rd), .rd_data(rd_data),
        .st_dr(st_dr), .st_ovr(st_ovr), .st_par(st_par), .st_frm(st_frm),
        .st_brk(st_brk), .st_err(st_err)
    );

    // row: {vld, data[8], par,frm,brk,rd,st_rd, exp dr,ovr,par,frm,brk,err, exp rd_data[8]}
    localparam logic [27:0] TBL [NROW] = '{
        {1'b1, 8'h41, 5'b00000, 6'b100000, 8'h00},  // R1 store clean
        {1'b1, 8'h42, 5'b10000, 6'b100001, 8'h00},  // R6 flagged entry behind head, R3 head clean
        {1'b0, 8'h00, 5'b00010, 6'b101001, 8'h41},  // R8 read, R3 parity at head
        {1'b1, 8'h43, 5'b01000, 6'b101001, 8'h41},
        {1'b0, 8'h00, 5'b00010, 6'b100101, 8'h42},  // R3 framing at head
        {1'b0, 8'h00, 5'b00010, 6'b000000, 8'h43},  // R6 last bad entry leaves
        {1'b0, 8'h00, 5'b00100, 6'b100011, 8'h43},  // R4 break stored
        {1'b0, 8'h00, 5'b00100, 6'b100011, 8'h43},  // R5 held break ignored
        {1'b0, 8'h00, 5'b00010, 6'b000000, 8'h00},  // R4 break data 0x00
        {1'b0, 8'h00, 5'b00010, 6'b000000, 8'h00},  // R8 empty read
        {1'b1, 8'h55, 5'b00000, 6'b100000, 8'h00},  // R5 rearm
        {1'b0, 8'h00, 5'b00100, 6'b100001, 8'h00},  // R4 break again
        {1'b0, 8'h00, 5'b00010, 6'b100011, 8'h55},
        {1'b0, 8'h00, 5'b00010, 6'b000000, 8'h00},
        {1'b1, 8'h66, 5'b00100, 6'b100000, 8'h00},  // R5 char wins over break
        {1'b0, 8'h00, 5'b00010, 6'b000000, 8'h66}
    };

    task automatic step(input logic v, input logic [7:0] d, input logic p, input logic f,
                        input logic b, input logic r, input logic s);
        chr_vld = v; chr_data = d; chr_par = p; chr_frm = f;
        brk_stb = b; rd_stb = r; st_rd = s;
        @(negedge clk);
        chr_vld = 1'b0; chr_data = 8'h00; chr_par = 1'b0; chr_frm = 1'b0;
        brk_stb = 1'b0; rd_stb = 1'b0; st_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R10 reset state
        chk("R10 reset", {2'b0, st_dr, st_ovr, st_par, st_frm, st_brk, st_err, rd_data},
            16'h0000);

        for (int i = 0; i < NROW; i++) begin
            logic [27:0] row;
            row = TBL[i];
            step(row[27], row[26:19], row[18], row[17], row[16], row[15], row[14]);
            chk($sformatf("table row %0d (R1 R3 R4 R5 R6 R8)", i),
                {2'b0, st_dr, st_ovr, st_par, st_frm, st_brk, st_err, rd_data},
                {2'b0, row[13:0]});
        end

        // R11 / R2 fill to capacity, then overrun
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 8'h10 + 8'(i), 0, 0, 0, 0, 0);
        chk("R11 full no overrun", {14'b0, st_dr, st_ovr}, 16'h0002);
        step(1'b1, 8'hEE, 0, 0, 0, 0, 0);
        chk("R2 overrun set", {15'b0, st_ovr}, 16'h0001);
        step(1'b1, 8'hEF, 0, 0, 0, 0, 1'b1);
        chk("R7 status read with new overrun keeps bit", {15'b0, st_ovr}, 16'h0001);
        step(1'b0, 8'h00, 0, 0, 0, 0, 1'b1);
        chk("R7 status read clears overrun", {15'b0, st_ovr}, 16'h0000);
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 8'h00, 0, 0, 0, 1'b1, 0);
            chk($sformatf("R11 R2 order entry %0d", i), {8'h00, rd_data}, {8'h00, 8'h10 + 8'(i)});
        end
        chk("R1 empty after drain", {15'b0, st_dr}, 16'h0000);
        step(1'b0, 8'h00, 0, 0, 0, 1'b1, 0);
        chk("R8 empty read keeps data", {8'h00, rd_data}, 16'h001F);

        // R9 holding register mode
        do_reset();
        fifo_en = 1'b0;
        step(1'b1, 8'h21, 0, 0, 0, 0, 0);
        step(1'b1, 8'h22, 0, 0, 0, 0, 0);
        chk("R9 second char overruns", {14'b0, st_dr, st_ovr}, 16'h0003);
        step(1'b0, 8'h00, 0, 0, 0, 1'b1, 0);
        chk("R9 first char kept", {7'b0, st_dr, rd_data}, 16'h0021);
        fifo_en = 1'b1;

        // R6 simultaneous store and read
        do_reset();
        step(1'b1, 8'h31, 1'b1, 0, 0, 0, 0);
        step(1'b1, 8'h32, 0, 0, 0, 1'b1, 0);
        chk("R6 flagged pop with clean push", {14'b0, st_dr, st_err}, 16'h0002);
        step(1'b1, 8'h33, 0, 1'b1, 0, 1'b1, 0);
        chk("R6 clean pop with flagged push", {13'b0, st_dr, st_frm, st_err}, 16'h0007);
        step(1'b0, 8'h00, 0, 0, 0, 1'b1, 0);
        chk("R6 summary clears", {14'b0, st_dr, st_err}, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule